// File: doc/BRIEF.md
# Memory Operation Ordering Matrix

This block decides when each memory function unit may proceed without breaking memory ordering. Every unit holds one load, one store, or one atomic operation, which is both a load and a store. When an operation issues into a unit, the unit records a row of wait bits. The row has one bit for each older memory operation that the new operation must stay behind. A store waits on every older operation. A load waits only on older operations that carry the store flag. Two loads never order each other.

A wait bit clears in one of two ways. The first is when the older unit retires. The second is when both units have generated their addresses, both are marked as progress candidates in the current cycle, and their compared address fields differ. A unit whose address has not been generated keeps all its waits. A unit left out of the candidate mask also keeps them.

Up to `ISW` operations can issue in one cycle. A lower slot is older than a higher slot. A younger slot builds its row from the registered unit state plus the older slots of the same cycle, so two units never wait on each other. A unit raises its go flag once its address is generated and its row is empty.

Top module: `memdep_matrix`

## Requirements
- R1: While `rst_n` is low, every unit is idle and `go` is all zero.
- R2: A load-only operation records no wait on an older load-only operation, even when both addresses fall in the same granule.
- R3: A store records a wait on every older busy unit. A load records a wait on every older busy unit whose store flag is set.
- R4: An operation that issues with both `iss_ld` and `iss_st` set is atomic. Younger loads and stores wait on it, and it waits on older loads and stores.
- R5: A wait bit of unit u on unit v clears at a clock edge only in two cases. One is that u and v both have generated addresses, both have their `cand` bit set in that cycle, and their compared fields differ. The other is that v retires through `done`. A unit without a generated address keeps every wait it holds.
- R6: `done[u]` on a busy unit returns it to idle. The same edge clears every other unit's wait on u.
- R7: `go[u]` is high exactly when unit u is busy, its address has been generated, and it holds no waits. The earliest `go` is the cycle after the `agen_vld` strobe. Once high, `go[u]` stays high until `done[u]`.
- R8: Within one issue cycle, slot 0 is older than slot 1. A younger slot waits on an older slot of the same cycle under the rules of R2 to R4.
- R9: An issue naming a unit that is already busy is ignored, and the unit keeps its type, address and waits. An address strobe or `done` naming an idle unit is also ignored.
- R10: Addresses are compared on bits [11:4] only. Two addresses that differ only below bit 4, or only above bit 11, count as matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | ISW | Issue valid per slot, slot 0 oldest |
| iss_unit | input | ISW*UW | Target unit index per slot |
| iss_ld | input | ISW | Slot carries a load (atomic when set with iss_st) |
| iss_st | input | ISW | Slot carries a store |
| agen_vld | input | 1 | Address generated this cycle |
| agen_unit | input | UW | Unit whose address is generated |
| agen_addr | input | AW | Generated address |
| cand | input | N | Units put forward for progress this cycle |
| done | input | N | Unit retires |
| go | output | N | Unit may proceed |

## Verification
The assertions check the following on every cycle. A wait bit only points at a busy unit and never at its own unit. No load-only unit waits on another load-only unit. Wait bits appear only when a unit is newly issued. A wait bit falls only after a retirement or while both units are generated candidates. A raised go flag holds until retirement. Whether the right waits were captured is shown only by the bench scenarios and its per-cycle reference comparison. These cover slot order within a cycle, atomic ordering, the masking by the candidate set, and the bits [11:4] compare window.

// File: rtl/memdep_matrix.sv
module memdep_matrix #(
  parameter int N      = 4,
  parameter int ISW    = 2,
  parameter int AW     = 32,
  parameter int CMP_LO = 4,
  parameter int CMP_HI = 11,
  localparam int UW    = (N > 1) ? $clog2(N) : 1,
  localparam int CW    = CMP_HI - CMP_LO + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ISW-1:0]   iss_vld,
  input  logic [ISW*UW-1:0] iss_unit,
  input  logic [ISW-1:0]   iss_ld,
  input  logic [ISW-1:0]   iss_st,
  input  logic             agen_vld,
  input  logic [UW-1:0]    agen_unit,
  input  logic [AW-1:0]    agen_addr,
  input  logic [N-1:0]     cand,
  input  logic [N-1:0]     done,
  output logic [N-1:0]     go
);

  logic [N-1:0]  busy, is_ld, is_st, agd;
  logic [CW-1:0] tag  [N];
  logic [N-1:0]  dep  [N];

  logic [N-1:0]  live, hit, nld, nst;
  logic [N-1:0]  nrow [N];
  logic [N-1:0]  rlx  [N];

  assign live = busy & ~done;

  always_comb begin
    logic [N-1:0]  sld, sst;
    logic [UW-1:0] ui;
    hit = '0;
    nld = '0;
    nst = '0;
    sld = '0;
    sst = '0;
    for (int k = 0; k < N; k++) nrow[k] = '0;
    for (int s = 0; s < ISW; s++) begin
      ui = iss_unit[s*UW +: UW];
      if (iss_vld[s] && (int'(ui) < N) && !busy[ui] && !hit[ui]) begin
        hit[ui] = 1'b1;
        nld[ui] = iss_ld[s];
        nst[ui] = iss_st[s];
        if (iss_st[s])      nrow[ui] = (live & (is_ld | is_st)) | sld | sst;
        else if (iss_ld[s]) nrow[ui] = (live & is_st) | sst;
        sld[ui] = iss_ld[s];
        sst[ui] = iss_st[s];
      end
    end
  end

  always_comb begin
    for (int u = 0; u < N; u++)
      for (int v = 0; v < N; v++)
        rlx[u][v] = cand[u] & cand[v] & agd[u] & agd[v] & (tag[u] != tag[v]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= '0;
      is_ld <= '0;
      is_st <= '0;
      agd   <= '0;
      for (int k = 0; k < N; k++) begin
        tag[k] <= '0;
        dep[k] <= '0;
      end
    end else begin
      for (int u = 0; u < N; u++) begin
        if (hit[u]) begin
          busy[u]  <= 1'b1;
          is_ld[u] <= nld[u];
          is_st[u] <= nst[u];
          agd[u]   <= 1'b0;
          dep[u]   <= nrow[u];
        end else if (done[u]) begin
          busy[u]  <= 1'b0;
          is_ld[u] <= 1'b0;
          is_st[u] <= 1'b0;
          agd[u]   <= 1'b0;
          dep[u]   <= '0;
        end else begin
          if (agen_vld && agen_unit == UW'(u) && busy[u]) begin
            agd[u] <= 1'b1;
            tag[u] <= agen_addr[CMP_HI:CMP_LO];
          end
          dep[u] <= dep[u] & ~done & ~rlx[u];
        end
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_go
    assign go[g] = busy[g] & agd[g] & ~(|dep[g]);

    a_r7_go_holds: assert property (@(posedge clk) disable iff (!rst_n)
      go[g] && !done[g] |=> go[g]);

    a_r3_no_self_wait: assert property (@(posedge clk) disable iff (!rst_n)
      !dep[g][g]);

    for (genvar h = 0; h < N; h++) begin : g_pair
      a_r6_wait_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dep[g][h] |-> busy[h]);

      a_r2_loads_free: assert property (@(posedge clk) disable iff (!rst_n)
        busy[g] && busy[h] && is_ld[g] && !is_st[g] && is_ld[h] && !is_st[h] |-> !dep[g][h]);

      a_r8_wait_born_at_issue: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dep[g][h]) |-> $past(!busy[g]));

      a_r5_wait_falls_on_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dep[g][h]) |-> $past(done[g] || done[h] ||
                                   (cand[g] && cand[h] && agd[g] && agd[h])));
    end
  end

endmodule

// File: tb/sim_memdep_matrix.sv
`timescale 1ns/1ps
module sim_memdep_matrix;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  iss_vld, iss_ld, iss_st;
  logic [3:0]  iss_unit;
  logic        agen_vld;
  logic [1:0]  agen_unit;
  logic [31:0] agen_addr;
  logic [3:0]  cand, done, go;

  int checks = 0;
  int errors = 0;
  bit fin = 0;

  always #2 clk = ~clk;

  memdep_matrix u0 (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_unit(iss_unit),
    .iss_ld(iss_ld), .iss_st(iss_st), .agen_vld(agen_vld), .agen_unit(agen_unit),
    .agen_addr(agen_addr), .cand(cand), .done(done), .go(go)
  );

  bit [N-1:0] mb, ml, ms, ma;
  bit [7:0]   mt [N];
  bit [N-1:0] md [N];

  function automatic bit [N-1:0] mgo();
    bit [N-1:0] r;
    for (int u = 0; u < N; u++) r[u] = mb[u] & ma[u] & (md[u] == '0);
    return r;
  endfunction

  task automatic model_reset();
    mb = '0; ml = '0; ms = '0; ma = '0;
    for (int u = 0; u < N; u++) begin mt[u] = '0; md[u] = '0; end
  endtask

  task automatic model_next();
    bit [N-1:0] live, hit, sld, sst;
    bit [N-1:0] nrow [N];
    bit [N-1:0] rl [N];
    bit [1:0] ut [2];
    live = mb & ~done;
    hit = '0; sld = '0; sst = '0;
    for (int u = 0; u < N; u++) nrow[u] = '0;
    for (int s = 0; s < 2; s++) begin
      int u;
      u = int'(iss_unit[s*2 +: 2]);
      ut[s] = iss_unit[s*2 +: 2];
      if (iss_vld[s] && !mb[u] && !hit[u]) begin
        hit[u] = 1;
        for (int v = 0; v < N; v++) begin
          bit oldst, oldany;
          oldst  = (live[v] & ms[v]) | sst[v];
          oldany = (live[v] & (ml[v] | ms[v])) | sld[v] | sst[v];
          if (iss_st[s]) nrow[u][v] = oldany;
          else if (iss_ld[s]) nrow[u][v] = oldst;
        end
        sld[u] = iss_ld[s];
        sst[u] = iss_st[s];
      end
    end
    for (int u = 0; u < N; u++)
      for (int v = 0; v < N; v++)
        rl[u][v] = cand[u] & cand[v] & ma[u] & ma[v] & (mt[u] != mt[v]);
    for (int u = 0; u < N; u++) begin
      if (hit[u]) begin
        mb[u] = 1; ml[u] = sld[u]; ms[u] = sst[u]; ma[u] = 0; md[u] = nrow[u];
      end else if (done[u]) begin
        mb[u] = 0; ml[u] = 0; ms[u] = 0; ma[u] = 0; md[u] = '0;
      end else begin
        if (agen_vld && int'(agen_unit) == u && mb[u]) begin
          ma[u] = 1; mt[u] = agen_addr[11:4];
        end
        md[u] = md[u] & ~done & ~rl[u];
      end
    end
  endtask

  task automatic clr();
    iss_vld = '0; iss_unit = '0; iss_ld = '0; iss_st = '0;
    agen_vld = 0; agen_unit = '0; agen_addr = '0; cand = '0; done = '0;
  endtask

  task automatic step();
    model_next();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (go !== mgo()) begin
      errors++;
      $display("FAIL R7 go=%b expected %b", go, mgo());
    end
    clr();
  endtask

  task automatic chk(input logic [3:0] exp, input string rq);
    checks++;
    if (go !== exp) begin
      errors++;
      $display("FAIL %s go=%b expected %b", rq, go, exp);
    end
  endtask

  task automatic iss(input int s, input int u, input bit l, input bit st);
    iss_vld[s] = 1; iss_unit[s*2 +: 2] = 2'(u); iss_ld[s] = l; iss_st[s] = st;
  endtask

  task automatic ag(input int u, input logic [31:0] a);
    agen_vld = 1; agen_unit = 2'(u); agen_addr = a;
  endtask

  initial begin
    clr();
    model_reset();
    repeat (3) @(negedge clk);
    chk(4'b0000, "R1");
    rst_n = 1;
    @(negedge clk);
    chk(4'b0000, "R1");

    // R2: two loads, same granule
    iss(0, 0, 1, 0); iss(1, 1, 1, 0); step();
    ag(0, 32'h100); step();
    ag(1, 32'h104); step();
    chk(4'b0011, "R2");
    done = 4'b0011; step();
    chk(4'b0000, "R6");

    // R3 / R10: store then load in same granule, low bits differ
    iss(0, 2, 0, 1); step();
    iss(0, 3, 1, 0); step();
    ag(2, 32'h200); step();
    ag(3, 32'h208); step();
    cand = 4'b1100; step();
    chk(4'b0100, "R10");
    done = 4'b0100; step();
    chk(4'b1000, "R6");
    done = 4'b1000; step();

    // R5: pending without address, then masked by cand
    iss(0, 0, 0, 1); step();
    iss(0, 1, 1, 0); step();
    ag(1, 32'h300); step();
    cand = 4'b1111; step();
    chk(4'b0000, "R5");
    ag(0, 32'h400); step();
    cand = 4'b0000; step();
    chk(4'b0001, "R5");
    cand = 4'b0001; step();
    chk(4'b0001, "R5");
    cand = 4'b0011; step();
    chk(4'b0011, "R5");
    done = 4'b0011; step();

    // R10: difference above bit 11 still matches
    iss(0, 0, 0, 1); step();
    iss(0, 1, 1, 0); step();
    ag(0, 32'h1500); step();
    ag(1, 32'h0500); step();
    cand = 4'b0011; step();
    chk(4'b0001, "R10");
    done = 4'b0011; step();

    // R4: atomic between loads
    iss(0, 0, 1, 0); step();
    iss(0, 1, 1, 1); iss(1, 2, 1, 0); step();
    ag(0, 32'h600); step();
    ag(1, 32'h600); step();
    ag(2, 32'h600); step();
    chk(4'b0001, "R4");
    done = 4'b0001; step();
    chk(4'b0010, "R4");
    done = 4'b0010; step();
    chk(4'b0100, "R4");
    done = 4'b0100; step();

    // R8: slot order within a cycle
    iss(0, 0, 0, 1); iss(1, 1, 1, 0); step();
    ag(0, 32'h700); step();
    ag(1, 32'h700); step();
    chk(4'b0001, "R8");
    done = 4'b0011; step();
    iss(0, 1, 1, 0); iss(1, 0, 0, 1); step();
    ag(0, 32'h700); step();
    ag(1, 32'h700); step();
    chk(4'b0010, "R8");
    done = 4'b0011; step();

    // R9: issue to busy unit and strobe to idle unit ignored
    iss(0, 3, 1, 0); step();
    ag(3, 32'h800); step();
    chk(4'b1000, "R9");
    iss(0, 3, 0, 1); step();
    chk(4'b1000, "R9");
    ag(2, 32'h900); step();
    iss(0, 2, 1, 0); step();
    step();
    chk(4'b1000, "R9");
    done = 4'b1100; step();
    chk(4'b0000, "R6");

    // constrained random
    void'($urandom(32'd4242));
    for (int c = 0; c < 4000; c++) begin
      for (int s = 0; s < 2; s++) begin
        if ($urandom % 3 == 0) begin
          int r, u;
          r = $urandom % 5;
          u = (s == 1 && iss_vld[0]) ? (int'(iss_unit[1:0]) + 1 + $urandom % 3) % 4 : $urandom % 4;
          iss(s, u, (r < 2) || (r == 4), (r >= 2));
        end
      end
      begin
        int u;
        u = $urandom % 4;
        if (mb[u] && !ma[u] && ($urandom % 2 == 0))
          ag(u, ($urandom & 32'hFFFF_F00F) | (32'($urandom % 3) << 4));
      end
      cand = 4'($urandom);
      for (int u = 0; u < N; u++)
        if ((mgo()[u] && $urandom % 3 == 0) || (mb[u] && $urandom % 40 == 0)) done[u] = 1;
      step();
    end

    if (!fin) begin
      fin = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule